// File: doc/BRIEF.md
# Page Entry Attribute Checker

This unit vets one 32-bit page mapping entry per transaction. A requester presents the entry, the word address it was read from, the kind of access (read or write) and the requester's privilege level (user or supervisor). The unit then reports one of three outcomes: the access is allowed, the entry is not present, or the access breaks the entry's protection. It also resolves the memory attributes of the mapped page into a cacheable bit and a write-through bit. Two global inputs bear on this. A write-protect strap applies read-only protection to supervisor writes. A cache-off input overrides the per-page cache bits.

When an access succeeds on an entry whose accessed bit is still clear, the unit sets that bit. It then sends the updated word back to the entry's address through a single-word write port. The unit waits for the write acknowledge before it responds. The request side uses a valid/ready handshake. The response is a single-cycle pulse that carries the outcome, the attributes and the updated entry. The request fields and both global inputs are captured at acceptance, so changes on those inputs during a transaction have no effect on it.

Top module: `pte_attr_unit`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_wr_en are both 0.
- R2: An entry with bit 0 (present) at 0 returns rsp_fault = 1 (not present), rsp_cacheable = 0 and rsp_wthru = 0. It returns the entry unchanged and issues no write.
- R3: A user access (req_user = 1) to an entry with bit 2 at 0 (supervisor page) returns rsp_fault = 2 (protection). So does a user write to an entry with bit 1 at 0 (read-only page).
- R4: A supervisor write to a read-only page returns rsp_fault = 2 only when wp_strap is 1, and succeeds (rsp_fault = 0) when it is 0. Supervisor reads ignore bits 1 and 2.
- R5: For a present entry with cache_off at 0, rsp_cacheable is the inverse of bit 4 and rsp_wthru equals bit 3. This holds also when the access faults for protection.
- R6: With cache_off at 1, a present entry reports rsp_cacheable = 0 and rsp_wthru = 0, whatever bits 3 and 4 hold.
- R7: A successful access to an entry with bit 5 (accessed) at 0 returns the entry with bit 5 set and every other bit unchanged. It writes that same word exactly once to the request's address.
- R8: An entry whose bit 5 is already 1, or an access that faults, produces no write. In that case the response carries the entry unchanged.
- R9: req_ready is 0 from the cycle after acceptance until the response cycle has passed. mem_wr_en stays high with stable address and data until mem_wr_done is seen. Request inputs that change after acceptance do not alter the response.
- R10: With no write, rsp_valid is 1 in the cycle right after acceptance. With a write, rsp_valid is 1 in the cycle after the one in which mem_wr_done is sampled high. rsp_valid lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit is idle and takes a request |
| req_entry | input | 32 | Page mapping entry to check |
| req_addr | input | AW | Word address the entry came from |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-level requester, 0 = supervisor |
| wp_strap | input | 1 | Apply read-only protection to supervisor writes |
| cache_off | input | 1 | Global cache disable override |
| mem_wr_en | output | 1 | Write-back request, held until acknowledged |
| mem_wr_addr | output | AW | Write-back word address |
| mem_wr_data | output | 32 | Write-back data (updated entry) |
| mem_wr_done | input | 1 | Write-back acknowledge |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_cacheable | output | 1 | Resolved: page may be cached |
| rsp_wthru | output | 1 | Resolved: write-through policy |
| rsp_entry | output | 32 | Entry after the accessed-bit update |

## Verification
The hardest case to reach is a write-back whose acknowledge arrives several cycles late while the request inputs keep changing. Here the response must still reflect the captured entry and must wait for the acknowledge. The bench's memory model holds mem_wr_done low for a chosen number of cycles. During that stall the bench scrambles req_entry, req_user and cache_off. It then checks the write count, the write data and address, the response latency and the response contents against values worked out from the original request.

// File: rtl/pte_attr_pkg.sv
// Package: bit positions, fault codes and shared types of the page entry
// attribute checker. Assumes a 32-bit entry with the flag bits low.
package pte_attr_pkg;
    localparam int ENTRY_W = 32;
    localparam int B_PRES  = 0;
    localparam int B_RW    = 1;
    localparam int B_USER  = 2;
    localparam int B_WT    = 3;
    localparam int B_NC    = 4;
    localparam int B_ACC   = 5;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_RSP  = 2'd2
    } state_e;

    typedef struct packed {
        logic cacheable;
        logic wthru;
    } cattr_t;
endpackage

// File: rtl/pte_perm_check.sv
// Module: pte_perm_check
// Combinational protection check for one access. Assumes the caller
// supplies only the present, writable and user flags of the entry.
module pte_perm_check
    import pte_attr_pkg::*;
(
    input  logic   present,
    input  logic   writable,
    input  logic   user_page,
    input  logic   is_write,
    input  logic   is_user,
    input  logic   wp_on,
    output fault_e fault
);
    logic ro_hit;

    // Decide the outcome: absence dominates, then privilege, then write rules.
    always_comb begin
        ro_hit = is_write && !writable && (is_user || wp_on);
        if (!present) begin
            fault = FLT_ABSENT;
        end else if ((is_user && !user_page) || ro_hit) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/pte_cache_resolve.sv
// Module: pte_cache_resolve
// Resolves per-page cache bits against the global cache-off override.
// Assumes an absent entry must report neither caching nor write-through.
module pte_cache_resolve
    import pte_attr_pkg::*;
(
    input  logic   present,
    input  logic   wt_bit,
    input  logic   nc_bit,
    input  logic   cache_off,
    output cattr_t attr
);
    logic nc_eff;

    // Force non-cacheable under the override and drop the policy bit.
    always_comb begin
        nc_eff         = nc_bit || cache_off;
        attr.cacheable = present && !nc_eff;
        attr.wthru     = present && !cache_off && wt_bit;
    end
endmodule

// File: rtl/pte_attr_ctrl.sv
// Module: pte_attr_ctrl
// Handshake sequencer. Captures precomputed results at acceptance, runs an
// optional held write-back, then pulses the response for one cycle.
// Assumes mem_wr_done is only meaningful while mem_wr_en is high.
module pte_attr_ctrl
    import pte_attr_pkg::*;
#(
    parameter int AW = 30,
    parameter int EW = ENTRY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  fault_e        in_fault,
    input  cattr_t        in_attr,
    input  logic [EW-1:0] in_entry,
    input  logic [AW-1:0] in_addr,
    input  logic          in_need_wb,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [EW-1:0] mem_wr_data,
    input  logic          mem_wr_done,
    output logic          rsp_valid,
    output fault_e        rsp_fault,
    output cattr_t        rsp_attr,
    output logic [EW-1:0] rsp_entry
);
    state_e        state_q;
    state_e        state_d;
    fault_e        fault_q;
    cattr_t        attr_q;
    logic [EW-1:0] entry_q;
    logic [AW-1:0] addr_q;
    logic          accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next-state choice for the transaction sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept) state_d = in_need_wb ? ST_WB : ST_RSP;
            ST_WB:   if (mem_wr_done) state_d = ST_RSP;
            ST_RSP:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the results of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= FLT_NONE;
            attr_q  <= '0;
            entry_q <= '0;
            addr_q  <= '0;
        end else if (accept) begin
            fault_q <= in_fault;
            attr_q  <= in_attr;
            entry_q <= in_entry;
            addr_q  <= in_addr;
        end
    end

    // Drive the handshake, write port and response outputs.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_wr_en   = (state_q == ST_WB);
        mem_wr_addr = addr_q;
        mem_wr_data = entry_q;
        rsp_valid   = (state_q == ST_RSP);
        rsp_fault   = fault_q;
        rsp_attr    = attr_q;
        rsp_entry   = entry_q;
    end
endmodule

// File: rtl/pte_attr_unit.sv
// Module: pte_attr_unit (top)
// Page entry attribute checker: protection check, cache attribute
// resolution and accessed-bit write-back in one handshaked transaction.
// Assumes request inputs are stable in the cycle they are offered.
module pte_attr_unit
    import pte_attr_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ENTRY_W-1:0] req_entry,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               wp_strap,
    input  logic               cache_off,
    output logic               mem_wr_en,
    output logic [AW-1:0]      mem_wr_addr,
    output logic [ENTRY_W-1:0] mem_wr_data,
    input  logic               mem_wr_done,
    output logic               rsp_valid,
    output logic [1:0]         rsp_fault,
    output logic               rsp_cacheable,
    output logic               rsp_wthru,
    output logic [ENTRY_W-1:0] rsp_entry
);
    fault_e             chk_fault;
    cattr_t             chk_attr;
    logic               mark_acc;
    logic [ENTRY_W-1:0] upd_entry;
    fault_e             out_fault;
    cattr_t             out_attr;

    pte_perm_check u_perm (
        .present   (req_entry[B_PRES]),
        .writable  (req_entry[B_RW]),
        .user_page (req_entry[B_USER]),
        .is_write  (req_write),
        .is_user   (req_user),
        .wp_on     (wp_strap),
        .fault     (chk_fault)
    );

    pte_cache_resolve u_cache (
        .present   (req_entry[B_PRES]),
        .wt_bit    (req_entry[B_WT]),
        .nc_bit    (req_entry[B_NC]),
        .cache_off (cache_off),
        .attr      (chk_attr)
    );

    // Set the accessed bit only on a clean access that finds it clear.
    always_comb begin
        mark_acc           = (chk_fault == FLT_NONE) && !req_entry[B_ACC];
        upd_entry          = req_entry;
        upd_entry[B_ACC]   = req_entry[B_ACC] || (chk_fault == FLT_NONE);
    end

    pte_attr_ctrl #(.AW(AW), .EW(ENTRY_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .in_fault    (chk_fault),
        .in_attr     (chk_attr),
        .in_entry    (upd_entry),
        .in_addr     (req_addr),
        .in_need_wb  (mark_acc),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_done (mem_wr_done),
        .rsp_valid   (rsp_valid),
        .rsp_fault   (out_fault),
        .rsp_attr    (out_attr),
        .rsp_entry   (rsp_entry)
    );

    // Flatten response types onto plain ports.
    always_comb begin
        rsp_fault     = out_fault;
        rsp_cacheable = out_attr.cacheable;
        rsp_wthru     = out_attr.wthru;
    end
endmodule

// File: rtl/pte_attr_unit_chk.sv
// Module: pte_attr_unit_chk
// Protocol and response checks for pte_attr_unit, attached by bind.
module pte_attr_unit_chk #(
    parameter int AW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_wr_addr,
    input logic [31:0]   mem_wr_data,
    input logic          mem_wr_done,
    input logic          rsp_valid,
    input logic [1:0]    rsp_fault,
    input logic          rsp_cacheable,
    input logic          rsp_wthru
);
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9
    AST_NO_READY_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !req_ready); // R9
    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_wr_done) |=> (mem_wr_en && $stable(mem_wr_data) && $stable(mem_wr_addr))); // R9
    AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wr_data[5]); // R7
    AST_DONE_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_wr_done) |=> (rsp_valid && !mem_wr_en)); // R10
    AST_ABSENT_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd1) |-> (!rsp_cacheable && !rsp_wthru)); // R2
    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> !$past(mem_wr_en)); // R8
endmodule

bind pte_attr_unit pte_attr_unit_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_wr_en     (mem_wr_en),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data),
    .mem_wr_done   (mem_wr_done),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cacheable (rsp_cacheable),
    .rsp_wthru     (rsp_wthru)
);

// File: tb/pte_attr_unit_tb.sv
module pte_attr_unit_tb;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_entry = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_user = 1'b0;
    logic          wp_strap = 1'b0;
    logic          cache_off = 1'b0;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0]   mem_wr_data;
    logic          mem_wr_done = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_fault;
    logic          rsp_cacheable;
    logic          rsp_wthru;
    logic [31:0]   rsp_entry;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // captured results of the last transaction
    logic [1:0]    g_fault;
    logic          g_cach;
    logic          g_wt;
    logic [31:0]   g_entry;
    int            g_wbs;
    logic [AW-1:0] g_wb_addr;
    logic [31:0]   g_wb_data;
    int            g_lat;
    bit            g_rdy_ok;

    always #10 clk = ~clk;

    pte_attr_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_entry(req_entry), .req_addr(req_addr), .req_write(req_write),
        .req_user(req_user), .wp_strap(wp_strap), .cache_off(cache_off),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_done(mem_wr_done), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cacheable(rsp_cacheable), .rsp_wthru(rsp_wthru), .rsp_entry(rsp_entry)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One full transaction; the memory model acknowledges after ack_dly cycles.
    // When scramble is set, request inputs are changed after acceptance.
    task automatic run(input logic [31:0] ent, input bit wr, input bit usr, input bit wp,
                       input bit cd, input logic [AW-1:0] adr, input int ack_dly, input bit scramble);
        int  wcyc;
        bit  prev_en;
        bit  got;
        @(negedge clk);
        req_entry = ent; req_write = wr; req_user = usr; wp_strap = wp;
        cache_off = cd; req_addr = adr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            req_entry = ~ent; req_user = ~usr; cache_off = ~cd; req_write = ~wr;
            req_addr = ~adr; wp_strap = ~wp;
        end
        g_wbs = 0; g_lat = 1; g_rdy_ok = 1'b1; wcyc = 0; prev_en = 1'b0; got = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            if (rsp_valid) begin
                g_fault = rsp_fault; g_cach = rsp_cacheable; g_wt = rsp_wthru;
                g_entry = rsp_entry; got = 1'b1;
                if (req_ready) g_rdy_ok = 1'b0;
            end else begin
                if (req_ready) g_rdy_ok = 1'b0;
                if (mem_wr_en) begin
                    if (!prev_en) begin
                        g_wbs++; g_wb_addr = mem_wr_addr; g_wb_data = mem_wr_data;
                    end else if (mem_wr_addr != g_wb_addr || mem_wr_data != g_wb_data) begin
                        g_rdy_ok = 1'b0;
                    end
                    mem_wr_done = (wcyc == ack_dly);
                    wcyc++;
                end else begin
                    mem_wr_done = 1'b0;
                end
                prev_en = mem_wr_en;
                @(negedge clk);
                g_lat++;
            end
        end
        mem_wr_done = 1'b0;
        chk(got, "R10 response seen", 64'(got), 64'd1);
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R10 ready returns, strobe one cycle",
            64'({req_ready, rsp_valid}), 64'b10);
        req_entry = '0; req_user = 1'b0; cache_off = 1'b0; req_write = 1'b0; wp_strap = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0 && mem_wr_en == 1'b0, "R1 idle outputs after reset",
            64'({rsp_valid, mem_wr_en}), 64'd0);
    endtask

    task automatic t_absent();
        run(32'h1234_5FFE, 1'b1, 1'b0, 1'b0, 1'b0, 30'h10, 0, 1'b0);
        chk(g_fault == 2'd1, "R2 absent fault code", 64'(g_fault), 64'd1);
        chk(!g_cach && !g_wt, "R2 absent attributes", 64'({g_cach, g_wt}), 64'd0);
        chk(g_entry == 32'h1234_5FFE, "R2 entry unchanged", 64'(g_entry), 64'h1234_5FFE);
        chk(g_wbs == 0, "R2 no write", 64'(g_wbs), 64'd0);
    endtask

    task automatic t_user_prot();
        // user read of a supervisor page, PWT set, PCD clear
        run(32'h0000_300B, 1'b0, 1'b1, 1'b0, 1'b0, 30'h20, 0, 1'b0);
        chk(g_fault == 2'd2, "R3 user to supervisor page", 64'(g_fault), 64'd2);
        chk(g_cach && g_wt, "R5 attributes on protection fault", 64'({g_cach, g_wt}), 64'b11);
        chk(g_wbs == 0 && g_entry == 32'h0000_300B, "R8 fault leaves entry, no write",
            64'({g_wbs[7:0], g_entry}), 64'h0000_300B);
        // user write to a read-only user page
        run(32'h0000_4005, 1'b1, 1'b1, 1'b0, 1'b0, 30'h21, 0, 1'b0);
        chk(g_fault == 2'd2, "R3 user write read-only", 64'(g_fault), 64'd2);
        // user read of a read-only user page is fine
        run(32'h0000_4025, 1'b0, 1'b1, 1'b0, 1'b0, 30'h22, 0, 1'b0);
        chk(g_fault == 2'd0, "R3 user read read-only allowed", 64'(g_fault), 64'd0);
    endtask

    task automatic t_sup_wp();
        run(32'h0000_5021, 1'b1, 1'b0, 1'b0, 1'b0, 30'h30, 0, 1'b0);
        chk(g_fault == 2'd0, "R4 supervisor write RO, strap off", 64'(g_fault), 64'd0);
        run(32'h0000_5021, 1'b1, 1'b0, 1'b1, 1'b0, 30'h31, 0, 1'b0);
        chk(g_fault == 2'd2, "R4 supervisor write RO, strap on", 64'(g_fault), 64'd2);
        run(32'h0000_5021, 1'b0, 1'b0, 1'b1, 1'b0, 30'h32, 0, 1'b0);
        chk(g_fault == 2'd0, "R4 supervisor read ignores RW/US", 64'(g_fault), 64'd0);
    endtask

    task automatic t_cache();
        run(32'h0000_002F, 1'b0, 1'b0, 1'b0, 1'b0, 30'h40, 0, 1'b0);
        chk(g_cach == 1'b1 && g_wt == 1'b1, "R5 cacheable write-through",
            64'({g_cach, g_wt}), 64'b11);
        run(32'h0000_0033, 1'b0, 1'b0, 1'b0, 1'b0, 30'h41, 0, 1'b0);
        chk(g_cach == 1'b0 && g_wt == 1'b0, "R5 non-cacheable write-back",
            64'({g_cach, g_wt}), 64'b00);
        run(32'h0000_0023, 1'b0, 1'b0, 1'b0, 1'b0, 30'h42, 0, 1'b0);
        chk(g_cach == 1'b1 && g_wt == 1'b0, "R5 cacheable write-back",
            64'({g_cach, g_wt}), 64'b10);
    endtask

    task automatic t_cache_off();
        run(32'h0000_002F, 1'b0, 1'b0, 1'b0, 1'b1, 30'h50, 0, 1'b0);
        chk(g_cach == 1'b0 && g_wt == 1'b0, "R6 override clears both",
            64'({g_cach, g_wt}), 64'b00);
    endtask

    task automatic t_accessed();
        run(32'hABCD_E00F, 1'b1, 1'b1, 1'b0, 1'b0, 30'h0123_4567, 3, 1'b1);
        chk(g_entry == 32'hABCD_E02F, "R7 accessed bit set, rest kept", 64'(g_entry), 64'hABCD_E02F);
        chk(g_wbs == 1, "R7 exactly one write", 64'(g_wbs), 64'd1);
        chk(g_wb_data == 32'hABCD_E02F && g_wb_addr == 30'h0123_4567, "R7 write data/addr",
            64'({g_wb_addr, g_wb_data}), {2'b0, 30'h0123_4567, 32'hABCD_E02F});
        chk(g_lat == 5, "R10 response after delayed ack", 64'(g_lat), 64'd5);
        chk(g_rdy_ok, "R9 busy and stable during write", 64'(g_rdy_ok), 64'd1);
        chk(g_fault == 2'd0 && g_cach && g_wt, "R9 captured inputs used",
            64'({g_fault, g_cach, g_wt}), 64'b0011);
        run(32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 30'h7, 0, 1'b0);
        chk(g_lat == 2 && g_wbs == 1, "R10 immediate ack latency", 64'(g_lat), 64'd2);
    endtask

    task automatic t_already();
        run(32'hABCD_E02F, 1'b1, 1'b1, 1'b0, 1'b0, 30'h60, 0, 1'b1);
        chk(g_wbs == 0, "R8 no write when accessed set", 64'(g_wbs), 64'd0);
        chk(g_entry == 32'hABCD_E02F, "R8 entry unchanged", 64'(g_entry), 64'hABCD_E02F);
        chk(g_lat == 1, "R10 no-write latency", 64'(g_lat), 64'd1);
        chk(g_rdy_ok, "R9 ready low until response", 64'(g_rdy_ok), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_absent();
        t_user_prot();
        t_sup_wp();
        t_cache();
        t_cache_off();
        t_accessed();
        t_already();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule